// File: doc/BRIEF.md
# Daisy-Chainable 16-Bit SPI Control Slave

This block is the serial command port of a controller for six half-bridges. A host talks to it over a four-wire serial link in clock mode 1. The host lowers chip select, clocks in 16-bit command words least significant bit first, and clocks out a 16-bit status word at the same time. The command takes effect only when chip select rises and the number of bits clocked in is a nonzero whole multiple of 16. Any other frame is thrown away, and the control register keeps its previous contents.

Because the count may be any multiple of 16, several of these slaves can be chained, with SO of one feeding SI of the next. After its own 16 status bits, each slave forwards the bits it received. Only the last 16 bits of a frame are committed. All three serial pins are brought into the system clock with two-flop synchronisers, and their edges are detected in that domain. The enable input gates all of the serial activity.

Top module: `hbctl_spi_slave`

## Requirements
- R1: When chip select falls with enable high, the status input is captured. SO then carries status bit 0, the thermal-warning flag, and status bits 1..15 follow in ascending order.
- R2: SI is sampled on each falling SCLK edge, least significant bit first. SO holds through the first rising SCLK edge of a frame and advances one bit on every later rising edge.
- R3: so_oe is low whenever chip select is high. It is high while chip select is low within a frame started with enable high.
- R4: On the rising edge of chip select, if the frame held a nonzero multiple of 16 SCLK falling edges, the last 16 bits received are committed to the control outputs.
- R5: A frame of zero bits, or of a bit count that is not a multiple of 16, leaves every control output unchanged.
- R6: Committed word layout: bit 0 is the status-reset request. Bit 1+2k drives lo_en[k] and bit 2+2k drives hi_en[k], for bridges k=0..5. Bits 13, 14 and 15 drive cfg_ocur, cfg_uload and cfg_ovolt.
- R7: A committed word with bit 0 set gives exactly one stat_clr pulse, one clock long. An invalid frame, or a word with bit 0 clear, gives none.
- R8: With enable low, no frame starts, so_oe stays low and nothing commits. A frame during which enable drops is abandoned, even if enable returns before chip select rises.
- R9: After the 16 status bits, SO carries the bits received on SI in the order they arrived, delayed by 16 bit times.
- R10: After reset, every control output, stat_clr and so_oe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Block enable |
| cs_n | input | 1 | Chip select, active low (asynchronous pin) |
| sclk | input | 1 | Serial clock (asynchronous pin) |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out, valid while so_oe is high |
| so_oe | output | 1 | Output enable for the SO pad driver |
| status_in | input | 16 | Status word, bit 0 is the thermal warning |
| lo_en | output | 6 | Low-side enables, bridges 1..6 |
| hi_en | output | 6 | High-side enables, bridges 1..6 |
| cfg_ocur | output | 1 | Overcurrent-detect configuration bit |
| cfg_uload | output | 1 | Underload-detect configuration bit |
| cfg_ovolt | output | 1 | Overvoltage-lockout configuration bit |
| stat_clr | output | 1 | One-cycle status-reset pulse |

## Verification
A pin change reaches the edge detector after two synchroniser flops. The frame engine reacts on the third clock edge, so SO and so_oe are valid three clocks after a pin edge, and the control outputs and stat_clr follow one clock later. The bench drives every pin change on a falling clock edge. It holds each pin level for six system clocks before it samples SO, and it waits eight clocks after chip select rises before it compares the control outputs. stat_clr pulses are counted continuously, so a one-cycle pulse is caught whichever cycle it lands in. The sweep covers every frame length from 0 to 48 bits and a walking one across all command bits.

// File: rtl/hbctl_pkg.sv
package hbctl_pkg;
    // Position of the status-reset request in a command word.
    localparam int SRR_BIT  = 0;
    // Number of configuration bits after the bridge enables.
    localparam int CFG_BITS = 3;

    // Command word width for a given bridge count.
    function automatic int word_width(input int n_bridges);
        return 1 + 2 * n_bridges + CFG_BITS;
    endfunction
endpackage

// File: rtl/hbctl_sync.sv
module hbctl_sync #(
    parameter int             N       = 3,
    parameter int             STAGES  = 2,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    logic [N-1:0] stg_d [STAGES];
    logic [N-1:0] stg_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stg_d[s] = async_in;
            end else begin : g_next
                always_comb stg_d[s] = stg_q[s-1];
            end
            always_ff @(posedge clk) begin
                if (rst) stg_q[s] <= RST_VAL;
                else     stg_q[s] <= stg_d[s];
            end
        end
    endgenerate

    assign sync_out = stg_q[STAGES-1];
endmodule

// File: rtl/hbctl_frame_eng.sv
module hbctl_frame_eng #(
    parameter int W     = 16,
    localparam int CNT_W = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         cs_s,
    input  logic         sck_s,
    input  logic         si_s,
    input  logic [W-1:0] status,
    output logic         so,
    output logic         so_oe,
    output logic         commit,
    output logic [W-1:0] word
);
    typedef struct packed {
        logic             cs_p;
        logic             sck_p;
        logic             in_frame;
        logic             seen;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     rx;
        logic [W-1:0]     tx;
        logic             oe;
        logic             commit;
    } eng_t;

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(W - 1);

    eng_t st_d, st_q;
    logic cs_fall, cs_rise, sck_fall, sck_rise;

    always_comb begin
        cs_fall  =  st_q.cs_p  & ~cs_s;
        cs_rise  = ~st_q.cs_p  &  cs_s;
        sck_fall =  st_q.sck_p & ~sck_s;
        sck_rise = ~st_q.sck_p &  sck_s;

        st_d        = st_q;
        st_d.cs_p   = cs_s;
        st_d.sck_p  = sck_s;
        st_d.commit = 1'b0;

        if (!en) begin
            st_d.in_frame = 1'b0;
        end else if (cs_fall) begin
            st_d.in_frame = 1'b1;
            st_d.seen     = 1'b0;
            st_d.cnt      = '0;
            st_d.tx       = status;
        end else if (cs_rise) begin
            st_d.commit   = st_q.in_frame & st_q.seen & (st_q.cnt == '0);
            st_d.in_frame = 1'b0;
        end else if (cs_s) begin
            st_d.in_frame = 1'b0;
        end else if (st_q.in_frame) begin
            if (sck_fall) begin
                st_d.rx   = {si_s, st_q.rx[W-1:1]};
                st_d.seen = 1'b1;
                st_d.cnt  = (st_q.cnt == CNT_LAST) ? '0 : st_q.cnt + 1'b1;
            end
            if (sck_rise && st_q.seen) begin
                st_d.tx = {st_q.rx[W-1], st_q.tx[W-1:1]};
            end
        end

        st_d.oe = st_d.in_frame;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.cs_p  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign so     = st_q.tx[0];
    assign so_oe  = st_q.oe;
    assign commit = st_q.commit;
    assign word   = st_q.rx;

    a_r8_oe_off_disabled: assert property (@(posedge clk) disable iff (rst)
        !en |=> !so_oe);

    a_r3_oe_off_cs_high: assert property (@(posedge clk) disable iff (rst)
        (cs_s && $past(cs_s)) |-> !so_oe);

    a_r4_commit_after_rise: assert property (@(posedge clk) disable iff (rst)
        commit |-> ($past(cs_s) && !$past(cs_s, 2)));
endmodule

// File: rtl/hbctl_ctrl_reg.sv
module hbctl_ctrl_reg
    import hbctl_pkg::*;
#(
    parameter int NB = 6,
    localparam int W = word_width(NB)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          commit,
    input  logic [W-1:0]  word,
    output logic [NB-1:0] lo_en,
    output logic [NB-1:0] hi_en,
    output logic [CFG_BITS-1:0] cfg,
    output logic          clr
);
    typedef struct packed {
        logic [NB-1:0]       lo;
        logic [NB-1:0]       hi;
        logic [CFG_BITS-1:0] cfg;
        logic                clr;
    } ctl_t;

    ctl_t ct_d, ct_q;
    logic [NB-1:0] lo_w, hi_w;

    genvar k;
    generate
        for (k = 0; k < NB; k++) begin : g_bridge
            assign lo_w[k] = word[SRR_BIT + 1 + 2*k];
            assign hi_w[k] = word[SRR_BIT + 2 + 2*k];
        end
    endgenerate

    always_comb begin
        ct_d     = ct_q;
        ct_d.clr = 1'b0;
        if (commit) begin
            ct_d.lo  = lo_w;
            ct_d.hi  = hi_w;
            ct_d.cfg = word[W-1 -: CFG_BITS];
            ct_d.clr = word[SRR_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ct_q <= '0;
        else     ct_q <= ct_d;
    end

    assign lo_en = ct_q.lo;
    assign hi_en = ct_q.hi;
    assign cfg   = ct_q.cfg;
    assign clr   = ct_q.clr;

    a_r5_hold_without_commit: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(lo_en) && $stable(hi_en) && $stable(cfg)));

    a_r7_clr_single_cycle: assert property (@(posedge clk) disable iff (rst)
        clr |=> !clr);

    a_r7_clr_needs_commit: assert property (@(posedge clk) disable iff (rst)
        clr |-> $past(commit));
endmodule

// File: rtl/hbctl_spi_slave.sv
module hbctl_spi_slave
    import hbctl_pkg::*;
#(
    parameter int NB          = 6,
    parameter int SYNC_STAGES = 2,
    localparam int W          = word_width(NB)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          cs_n,
    input  logic          sclk,
    input  logic          si,
    output logic          so,
    output logic          so_oe,
    input  logic [W-1:0]  status_in,
    output logic [NB-1:0] lo_en,
    output logic [NB-1:0] hi_en,
    output logic          cfg_ocur,
    output logic          cfg_uload,
    output logic          cfg_ovolt,
    output logic          stat_clr
);
    logic [2:0]          pins_s;
    logic                commit;
    logic [W-1:0]        rx_word;
    logic [CFG_BITS-1:0] cfg;

    // Bit order: {cs, sclk, si}; chip select idles high.
    hbctl_sync #(
        .N       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) sync_i (
        .clk      (clk),
        .rst      (rst),
        .async_in ({cs_n, sclk, si}),
        .sync_out (pins_s)
    );

    hbctl_frame_eng #(.W(W)) eng_i (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .cs_s   (pins_s[2]),
        .sck_s  (pins_s[1]),
        .si_s   (pins_s[0]),
        .status (status_in),
        .so     (so),
        .so_oe  (so_oe),
        .commit (commit),
        .word   (rx_word)
    );

    hbctl_ctrl_reg #(.NB(NB)) ctl_i (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .word   (rx_word),
        .lo_en  (lo_en),
        .hi_en  (hi_en),
        .cfg    (cfg),
        .clr    (stat_clr)
    );

    assign cfg_ocur  = cfg[0];
    assign cfg_uload = cfg[1];
    assign cfg_ovolt = cfg[2];

    a_r10_idle_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (!so_oe && !stat_clr && lo_en == '0 && hi_en == '0));
endmodule

// File: tb/hbctl_spi_slave_tb_top.sv
module hbctl_spi_slave_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        si = 1'b0;
    logic        so, so_oe, stat_clr;
    logic [15:0] status_in = '0;
    logic [5:0]  lo_en, hi_en;
    logic        cfg_ocur, cfg_uload, cfg_ovolt;

    int checks = 0;
    int errors = 0;
    int clr_cnt = 0;
    logic [15:0] exp_ctrl = '0;
    logic [31:0] seed = 32'h1234_5678;
    bit done = 0;

    always #2.5 clk = ~clk;

    hbctl_spi_slave dut_i (
        .clk(clk), .rst(rst), .en(en), .cs_n(cs_n), .sclk(sclk), .si(si),
        .so(so), .so_oe(so_oe), .status_in(status_in),
        .lo_en(lo_en), .hi_en(hi_en), .cfg_ocur(cfg_ocur),
        .cfg_uload(cfg_uload), .cfg_ovolt(cfg_ovolt), .stat_clr(stat_clr)
    );

    always @(posedge clk) if (!rst && stat_clr) clr_cnt <= clr_cnt + 1;

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    // Command word rebuilt from the ports, bit 0 reads as zero.
    function automatic logic [15:0] act_word();
        logic [15:0] w = '0;
        for (int k = 0; k < 6; k++) begin
            w[1 + 2*k] = lo_en[k];
            w[2 + 2*k] = hi_en[k];
        end
        w[13] = cfg_ocur;
        w[14] = cfg_uload;
        w[15] = cfg_ovolt;
        return w;
    endfunction

    task automatic chk_ctrl(input string tag);
        chk(act_word() == {exp_ctrl[15:1], 1'b0}, tag, act_word(), {exp_ctrl[15:1], 1'b0});
    endtask

    // One SCLK period: rise, sample SO, set SI, fall.
    task automatic clk_bit(input logic b, output logic so_smp, output logic oe_smp);
        sclk = 1'b1;
        waitn(6);
        so_smp = so;
        oe_smp = so_oe;
        si = b;
        waitn(6);
        sclk = 1'b0;
        waitn(6);
    endtask

    task automatic do_frame(input int nbits, input logic [47:0] data,
                            input logic [15:0] status, input bit exp_oe);
        logic [79:0] stream;
        logic so_s, oe_s;
        int c0;
        bit valid;
        stream = {data[47:0], status};
        status_in = status;
        c0 = clr_cnt;
        cs_n = 1'b0;
        waitn(6);
        chk(so_oe == exp_oe, exp_oe ? "R3 oe in frame" : "R8 oe while disabled", so_oe, exp_oe);
        for (int i = 0; i < nbits; i++) begin
            clk_bit(data[i], so_s, oe_s);
            if (exp_oe) begin
                if (i < 16) chk(so_s == stream[i], "R1 status bit on SO", so_s, stream[i]);
                else        chk(so_s == stream[i], "R9 forwarded bit on SO", so_s, stream[i]);
            end else begin
                chk(oe_s == 1'b0, "R8 oe low while disabled", oe_s, 0);
            end
        end
        waitn(2);
        cs_n = 1'b1;
        waitn(8);
        chk(so_oe == 1'b0, "R3 oe after cs high", so_oe, 0);
        valid = exp_oe && nbits > 0 && (nbits % 16) == 0;
        if (valid) exp_ctrl = data[nbits-16 +: 16];
        if (valid) chk_ctrl("R4 R2 committed word");
        else if (exp_oe) chk_ctrl("R5 invalid frame kept");
        else chk_ctrl("R8 no commit while disabled");
        chk((clr_cnt - c0) == ((valid && exp_ctrl[0]) ? 1 : 0), "R7 clear pulse count",
            clr_cnt - c0, (valid && exp_ctrl[0]) ? 1 : 0);
        waitn(4);
    endtask

    initial begin
        waitn(190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic so_s, oe_s;
        int c0;
        waitn(8);
        rst = 1'b0;
        waitn(4);
        chk(act_word() == 16'h0, "R10 control outputs after reset", act_word(), 0);
        chk(so_oe == 1'b0, "R10 oe after reset", so_oe, 0);
        chk(stat_clr == 1'b0, "R10 clear after reset", stat_clr, 0);
        en = 1'b1;
        waitn(4);

        // Walking one over every command bit, field layout.
        for (int b = 0; b < 16; b++) begin
            do_frame(16, 48'(1) << b, rnd()[15:0], 1'b1);
            if (b >= 1 && b <= 12)
                chk(((b % 2) ? lo_en[(b-1)/2] : hi_en[(b-2)/2]) == 1'b1, "R6 bridge enable bit", b, 1);
            if (b >= 13)
                chk({cfg_ovolt, cfg_uload, cfg_ocur} == 3'(1 << (b-13)), "R6 config bit",
                    {cfg_ovolt, cfg_uload, cfg_ocur}, 3'(1 << (b-13)));
        end

        // Every frame length from 0 to 48 bits.
        for (int n = 0; n <= 48; n++) begin
            logic [47:0] d;
            d = {rnd()[15:0], rnd()};
            do_frame(n, d, rnd()[15:0], 1'b1);
        end

        // Disabled block.
        en = 1'b0;
        waitn(4);
        do_frame(16, 48'h0000_0000_FFFF, 16'hA5A5, 1'b0);
        en = 1'b1;
        waitn(4);

        // Enable drops mid-frame, returns before chip select rises.
        c0 = clr_cnt;
        cs_n = 1'b0;
        waitn(6);
        for (int i = 0; i < 8; i++) clk_bit(1'b1, so_s, oe_s);
        en = 1'b0;
        waitn(6);
        chk(so_oe == 1'b0, "R8 oe after enable drop", so_oe, 0);
        en = 1'b1;
        for (int i = 0; i < 8; i++) clk_bit(1'b1, so_s, oe_s);
        waitn(2);
        cs_n = 1'b1;
        waitn(8);
        chk_ctrl("R8 abandoned frame not committed");
        chk(clr_cnt == c0, "R8 no clear from abandoned frame", clr_cnt - c0, 0);

        // A valid frame still works afterwards.
        do_frame(32, 48'h0000_8001_1235, 16'h0F0F, 1'b1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule